// File: doc/BRIEF.md
# Fused Mixed-Radix Digit Generator

This combinational unit turns a residue triple for the three consecutive moduli 2m−1, 2m and 2m+1 into the two upper digits of its mixed-radix form. The radix order is 2m first, then 2m+1, then 2m−1. With that order the lowest digit is the residue modulo 2m itself. The unit produces the middle digit P, the top digit Q and a borrow flag. A later stage forms the binary integer as resEven + P·2m + Q·2m(2m+1).

P comes from a single subtraction modulo 2m+1. The inverse of 2m modulo 2m+1 is minus one, so no multiplier is needed. The borrow of that subtraction is ready before P and is fed straight into the Q path. Q is not found by a cascade of subtract, reduce and scale by m. It is found in one pass: five partial words and a carry-in go through a three-level carry-save tree and one carry-propagate adder. A single conditional add or subtract of 2m−1 then brings the result into range.

The design is split into a P subtractor, a Q summing tree, a Q correction stage and a small controller. The controller turns sign bits into mux strobes.

Top module: `mrd_digit_gen`

## Requirements
- R1: digitP equals (resEven − resInc) mod (2m+1).
- R2: digitP always lies in the range 0 to 2m inclusive.
- R3: borrow is 1 exactly when resEven < resInc, and 0 otherwise.
- R4: digitQ equals (m·resInc + m·resDec − resEven − borrow) mod (2m−1). This value is the top mixed-radix digit, floor(X / (2m(2m+1))).
- R5: digitQ always lies in the range 0 to 2m−2 inclusive.
- R6: for every X in [0, 2m(4m²−1)), driving the residues of X gives digits for which resEven + digitP·2m + digitQ·2m(2m+1) equals X.
- R7: an all-zero residue triple gives digitP = 0, digitQ = 0 and borrow = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| resDec | input | K | residue modulo 2m−1, canonical (0 to 2m−2) |
| resEven | input | K | residue modulo 2m, canonical (0 to 2m−1) |
| resInc | input | K | residue modulo 2m+1, canonical (0 to 2m) |
| digitP | output | K | middle mixed-radix digit (radix 2m+1) |
| digitQ | output | K | top mixed-radix digit (radix 2m−1) |
| borrow | output | 1 | sign of resEven − resInc |

K is $clog2(2m+1), where m is the parameter M.

## Verification
The embedded checks take it as given that every residue is already canonical for its modulus. Each check is guarded by an input-range test, because the bound on the raw Q sum, [−2m+1, 4m−4], and the single-correction argument hold only for canonical inputs. The stimulus never leaves that space. It walks every integer of the dynamic range and derives the three residues from each integer by division, so all possible triples are applied and none is out of range. The expected digits come from integer division of the same integer, not from the residue formulas.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  // strobes steering the P wrap and the direction of the Q correction
  typedef struct packed {
    logic pWrap;
    logic qWrap;
  } mrdPath_t;

  // strobe choosing the corrected or the raw Q word
  typedef struct packed {
    logic qTake;
  } mrdPick_t;
endpackage

// File: rtl/mrd_csa.sv
module mrd_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);
  assign sumOut   = opA ^ opB ^ opC;
  assign carryOut = (opA & opB) | (opA & opC) | (opB & opC);
endmodule

// File: rtl/mrd_p_path.sv
module mrd_p_path
  import mrd_pkg::*;
#(
  parameter int M = 5,
  parameter int K = 4
) (
  input  logic [K-1:0] resEven,
  input  logic [K-1:0] resInc,
  input  mrdPath_t     strb,
  output logic         diffSign,
  output logic [K-1:0] digitP
);
  localparam int W = K + 1;
  localparam logic [W-1:0] MOD_P = W'(2*M + 1);

  logic [W-1:0] diff;
  logic [W-1:0] wrapped;

  always_comb diff = {1'b0, resEven} - {1'b0, resInc};
  assign diffSign = diff[W-1];

  always_comb wrapped = diff + MOD_P;
  always_comb digitP  = strb.pWrap ? wrapped[K-1:0] : diff[K-1:0];

  always_comb begin
    if (int'(resEven) < 2*M && int'(resInc) <= 2*M) begin
      assert_borrow_sign_R3: assert (diffSign == (resEven < resInc))
        else $error("borrow disagrees with operand order");
      assert_p_fit_R2: assert (!strb.pWrap || wrapped[W-1] == 1'b0)
        else $error("wrapped P overflowed its width");
      assert_p_range_R2: assert (int'(digitP) <= 2*M)
        else $error("P above 2m");
    end
  end
endmodule

// File: rtl/mrd_q_sum.sv
module mrd_q_sum #(
  parameter int M = 5,
  parameter int K = 4
) (
  input  logic [K-1:0]   resDec,
  input  logic [K-1:0]   resEven,
  input  logic [K-1:0]   resInc,
  input  logic           borrowIn,
  output logic [K+1:0]   qSum
);
  localparam int S      = K + 2;
  localparam int NOPS   = 5;
  localparam int LEVELS = NOPS - 2;

  logic [NOPS-1:0][S-1:0]   ops;
  logic [LEVELS:0][S-1:0]   sumV;
  logic [LEVELS:0][S-1:0]   carryV;

  // each odd-modulus residue folds to upper word + m gated by its LSB
  assign ops[0] = {3'b000, resInc[K-1:1]};
  assign ops[1] = {3'b000, resDec[K-1:1]};
  assign ops[2] = resInc[0] ? S'(M) : '0;
  assign ops[3] = resDec[0] ? S'(M) : '0;
  assign ops[4] = ~{2'b00, resEven};

  assign sumV[0]   = ops[0];
  assign carryV[0] = ops[1];

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_tree
    logic [S-1:0] rawCarry;
    mrd_csa #(.W(S)) u_csa (
      .opA     (sumV[lvl]),
      .opB     (carryV[lvl]),
      .opC     (ops[lvl+2]),
      .sumOut  (sumV[lvl+1]),
      .carryOut(rawCarry)
    );
    assign carryV[lvl+1] = {rawCarry[S-2:0], 1'b0};
  end

  // inverted borrow enters as carry-in: -x2 - t == ~x2 + ~t
  assign qSum = sumV[LEVELS] + carryV[LEVELS] + {{(S-1){1'b0}}, ~borrowIn};

  always_comb begin
    if (int'(resDec) <= 2*M-2 && int'(resEven) < 2*M && int'(resInc) <= 2*M) begin
      assert_sum_window_R4: assert (int'($signed(qSum)) >= -(2*M-1) &&
                                    int'($signed(qSum)) <= 4*M-4)
        else $error("raw Q sum outside single-correction window");
    end
  end
endmodule

// File: rtl/mrd_q_fix.sv
module mrd_q_fix
  import mrd_pkg::*;
#(
  parameter int M = 5,
  parameter int K = 4
) (
  input  logic [K+1:0] qSum,
  input  mrdPath_t     strb,
  input  mrdPick_t     pick,
  output logic         adjSign,
  output logic [K-1:0] digitQ
);
  localparam int S = K + 2;
  localparam logic [S-1:0] MOD_Q = S'(2*M - 1);

  logic [S-1:0] adj;

  // one adder: add m1 when negative, else add its two's complement
  always_comb adj = qSum + (MOD_Q ^ {S{~strb.qWrap}}) + {{(S-1){1'b0}}, ~strb.qWrap};
  assign adjSign = adj[S-1];

  always_comb digitQ = pick.qTake ? adj[K-1:0] : qSum[K-1:0];

  always_comb begin
    assert_q_fit_R5: assert (!pick.qTake || adj[S-1:K] == '0)
      else $error("selected corrected Q does not fit K bits");
  end
endmodule

// File: rtl/mrd_ctrl.sv
module mrd_ctrl
  import mrd_pkg::*;
(
  input  logic     diffSign,
  input  logic     sumSign,
  input  logic     adjSign,
  output mrdPath_t path,
  output mrdPick_t pick
);
  always_comb begin
    path.pWrap = diffSign;
    path.qWrap = sumSign;
  end

  // negative sum: always take sum + m1; otherwise take sum - m1 if non-negative
  always_comb pick.qTake = sumSign | ~adjSign;
endmodule

// File: rtl/mrd_digit_gen.sv
module mrd_digit_gen
  import mrd_pkg::*;
#(
  parameter  int M = 5,
  localparam int K = $clog2(2*M + 1)
) (
  input  logic [K-1:0] resDec,
  input  logic [K-1:0] resEven,
  input  logic [K-1:0] resInc,
  output logic [K-1:0] digitP,
  output logic [K-1:0] digitQ,
  output logic         borrow
);
  logic         diffSign;
  logic         adjSign;
  logic [K+1:0] qSum;
  mrdPath_t     path;
  mrdPick_t     pick;

  mrd_p_path #(.M(M), .K(K)) u_pPath (
    .resEven (resEven),
    .resInc  (resInc),
    .strb    (path),
    .diffSign(diffSign),
    .digitP  (digitP)
  );

  mrd_q_sum #(.M(M), .K(K)) u_qSum (
    .resDec  (resDec),
    .resEven (resEven),
    .resInc  (resInc),
    .borrowIn(diffSign),
    .qSum    (qSum)
  );

  mrd_q_fix #(.M(M), .K(K)) u_qFix (
    .qSum   (qSum),
    .strb   (path),
    .pick   (pick),
    .adjSign(adjSign),
    .digitQ (digitQ)
  );

  mrd_ctrl u_ctrl (
    .diffSign(diffSign),
    .sumSign (qSum[K+1]),
    .adjSign (adjSign),
    .path    (path),
    .pick    (pick)
  );

  assign borrow = diffSign;

  always_comb begin
    if (int'(resDec) <= 2*M-2 && int'(resEven) < 2*M && int'(resInc) <= 2*M) begin
      assert_p_residue_R1: assert ((int'(digitP) + int'(resInc)) % (2*M+1) == int'(resEven))
        else $error("P not congruent to x2 - x3");
      assert_q_range_R5: assert (int'(digitQ) <= 2*M-2)
        else $error("Q above 2m-2");
      assert_q_residue_R4: assert (((M*int'(resInc) + M*int'(resDec) - int'(resEven)
                                     - int'(borrow) - int'(digitQ)) % (2*M-1)) == 0)
        else $error("Q not congruent to its defining sum");
    end
  end
endmodule

// File: tb/mrd_digit_gen_bench.sv
module mrd_digit_gen_bench;
  localparam int M    = 5;
  localparam int K    = $clog2(2*M + 1);
  localparam int MD   = 2*M - 1;
  localparam int ME   = 2*M;
  localparam int MI   = 2*M + 1;
  localparam int SPAN = MD * ME * MI;

  typedef struct {
    int x;
    int p;
    int q;
    int t;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] resDec = '0;
  logic [K-1:0] resEven = '0;
  logic [K-1:0] resInc = '0;
  logic [K-1:0] digitP;
  logic [K-1:0] digitQ;
  logic         borrow;

  item_t sbq[$];
  int    nRun  = 0;
  int    nFail = 0;
  bit    done  = 1'b0;

  always #2 clk = ~clk;

  mrd_digit_gen #(.M(M)) u_mrd_digit_gen (
    .resDec (resDec),
    .resEven(resEven),
    .resInc (resInc),
    .digitP (digitP),
    .digitQ (digitQ),
    .borrow (borrow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: applies the residues of x and queues the digits x implies
  task automatic drive(input int x);
    item_t it;
    @(posedge clk);
    #1;
    resDec  = K'(x % MD);
    resEven = K'(x % ME);
    resInc  = K'(x % MI);
    it.x = x;
    it.p = (x / ME) % MI;
    it.q = x / (ME * MI);
    it.t = ((x % ME) < (x % MI)) ? 1 : 0;
    sbq.push_back(it);
  endtask

  // monitor: compares at the falling edge after each drive
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      item_t it;
      int    rec;
      it  = sbq.pop_front();
      rec = (it.x % ME) + int'(digitP) * ME + int'(digitQ) * ME * MI;
      check(int'(digitP) == it.p, "R1 P digit", int'(digitP), it.p);
      check(int'(digitP) <= 2*M, "R2 P range", int'(digitP), 2*M);
      check(int'(borrow) == it.t, "R3 borrow", int'(borrow), it.t);
      check(int'(digitQ) == it.q, "R4 Q digit", int'(digitQ), it.q);
      check(int'(digitQ) <= 2*M-2, "R5 Q range", int'(digitQ), 2*M-2);
      check(rec == it.x, "R6 reconstruct", rec, it.x);
      if (it.x == 0) begin
        check(digitP == '0 && digitQ == '0 && borrow == 1'b0,
              "R7 zero triple", int'(digitP) + int'(digitQ) + int'(borrow), 0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(0);
    for (int x = 1; x < SPAN; x++) drive(x);
    drive(0);
    drive(SPAN - 1);
    while (sbq.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", sbq.size(), 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule